// File: doc/BRIEF.md
# Filtered and Unfiltered Press Tally

This block counts presses of one mechanical push button along two paths side by side, so that contact bounce shows up as a difference between two counts. The button is asynchronous. It first passes through a two-flop synchronizer. From there the signal splits into two paths. The filtered path runs through a debounce filter: a four-state machine with a settle timer that accepts a new level only after the level has held for a programmable number of cycles. The unfiltered path takes the synchronized level directly. Each path then drives its own rising-edge one-shot and its own wrapping press counter.

The two counts leave the block packed into one 16-bit word. The filtered count is in bits 7:0 and the unfiltered count is in bits 15:8. A display driver or a probe can read this word. Any press that bounces makes the upper byte move ahead of the lower byte.

The settle time is a parameter. At a 100 MHz clock, the default of 500000 cycles gives 5 ms. Reset is active-low. It asserts asynchronously and is released through a local two-flop reset synchronizer.

Top module: `press_tally`

## Requirements
- R1: While rst_ni is low, tally_o reads zero. After release with the button held low, tally_o stays zero.
- R2: The button passes through two synchronizer flops. A level that rises just after one clock edge leaves the unfiltered count unchanged through three further rising edges and raises it by one on the fourth.
- R3: The unfiltered count, bits 15:8, rises by exactly one for every 0-to-1 change of the button level as sampled on successive clock edges. One-cycle pulses count too. The count wraps from 255 to 0.
- R4: The filtered count, bits 7:0, rises by exactly one per press. A button held high for any length of time adds only that one count.
- R5: A high level of the synchronized button that spans at most SETTLE_CYCLES consecutive clock samples leaves the filtered count unchanged. A high level that spans SETTLE_CYCLES+1 samples counts one press.
- R6: Once the filtered level is high, it returns low only after the synchronized button has stayed low for SETTLE_CYCLES+1 consecutive samples. A shorter low gap inside a press adds no filtered count.
- R7: The filtered count wraps from 255 to 0 without saturating.
- R8: tally_o carries the filtered count in bits 7:0 and the unfiltered count in bits 15:8.
- R9: Asserting reset in the middle of operation clears both counts at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| button_i | input | 1 | Asynchronous push-button level, high while pressed |
| tally_o | output | 16 | {unfiltered press count, filtered press count} |

## Verification
The checker makes these assumptions about the inputs:
- The button is a plain level. It may change at any time.
- Reset is applied before the first press.

Its run-length counters watch the synchronized button, not the pin. The settle-time properties therefore hold whatever the pin does, as long as the synchronizer output is a clean level. The bench meets this by changing the button only on falling clock edges. Each level it drives is then sampled on whole rising edges, and the bench can count exactly the rising edges the synchronizer sees. Every bounce burst keeps its high and low segments within SETTLE_CYCLES samples, and every stable phase lasts at least SETTLE_CYCLES+1 samples. The expected count of filtered presses is therefore exact.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // Filter states: two stable levels and two qualification windows.
  typedef enum logic [1:0] {
    DB_LOW  = 2'b00,
    DB_RISE = 2'b01,
    DB_HIGH = 2'b10,
    DB_FALL = 2'b11
  } db_state_e;

  localparam int unsigned NPATH         = 2;
  localparam int unsigned FILTERED_PATH = 0;
  localparam int unsigned RAW_PATH      = 1;

endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pt_debounce.sv
module pt_debounce
  import pt_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic level_o
);

  localparam int unsigned TW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [TW-1:0] DONE_AT = TW'(SETTLE_CYCLES - 1);

  db_state_e     state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  logic          timer_clr;
  logic          timer_done;

  // Timer: runs whenever the machine does not hold it clear.
  assign timer_done = (timer_q == DONE_AT);
  assign timer_d    = timer_clr ? '0 : timer_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
    end else begin
      timer_q <= timer_d;
    end
  end

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    timer_clr = 1'b1;
    unique case (state_q)
      DB_LOW: begin
        if (level_i) state_d = DB_RISE;
      end
      DB_RISE: begin
        timer_clr = 1'b0;
        if (!level_i)       state_d = DB_LOW;
        else if (timer_done) state_d = DB_HIGH;
      end
      DB_HIGH: begin
        if (!level_i) state_d = DB_FALL;
      end
      DB_FALL: begin
        timer_clr = 1'b0;
        if (level_i)         state_d = DB_HIGH;
        else if (timer_done) state_d = DB_LOW;
      end
      default: state_d = DB_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DB_LOW;
    end else begin
      state_q <= state_d;
    end
  end

  assign level_o = (state_q == DB_HIGH) || (state_q == DB_FALL);

endmodule

// File: rtl/pt_oneshot.sv
module pt_oneshot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);

  logic f1_q, f2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f1_q <= 1'b0;
      f2_q <= 1'b0;
    end else begin
      f1_q <= level_i;
      f2_q <= f1_q;
    end
  end

  assign pulse_o = f1_q & ~f2_q;

endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] count_q, count_d;

  assign count_d = count_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (en_i) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/press_tally.sv
module press_tally
  import pt_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 500000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned COUNT_W       = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       button_i,
  output logic [NPATH*COUNT_W-1:0]   tally_o
);

  logic             rst_sync_n;
  logic             btn_sync;
  logic [NPATH-1:0] path_level;
  logic [NPATH-1:0] path_pulse;
  logic [COUNT_W-1:0] path_count [NPATH];

  // Reset: asserts at once, releases on a clock edge.
  pt_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  // Shared button synchronizer.
  pt_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (button_i),
    .q_o    (btn_sync)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    if (p == FILTERED_PATH) begin : g_filter
      pt_debounce #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_filter (
        .clk_i   (clk_i),
        .rst_ni  (rst_sync_n),
        .level_i (btn_sync),
        .level_o (path_level[p])
      );
    end else begin : g_direct
      assign path_level[p] = btn_sync;
    end

    pt_oneshot u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .level_i (path_level[p]),
      .pulse_o (path_pulse[p])
    );

    pt_counter #(.WIDTH(COUNT_W)) u_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .en_i    (path_pulse[p]),
      .count_o (path_count[p])
    );

    assign tally_o[p*COUNT_W +: COUNT_W] = path_count[p];
  end

endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int unsigned SETTLE_CYCLES = 500000,
  parameter int unsigned COUNT_W       = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2*COUNT_W-1:0] tally_i,
  input logic                 synced_i,
  input logic                 filtered_i
);

  localparam int unsigned RW = $clog2(SETTLE_CYCLES + 2) + 1;
  localparam logic [RW-1:0] NEED = RW'(SETTLE_CYCLES + 1);

  logic [RW-1:0] hi_run_q, lo_run_q;

  // Lengths of the current high and low runs of the synchronized button.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else if (synced_i) begin
      lo_run_q <= '0;
      if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
    end else begin
      hi_run_q <= '0;
      if (lo_run_q != '1) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> tally_i == '0);

  // R3
  p_raw_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tally_i[2*COUNT_W-1:COUNT_W] == $past(tally_i[2*COUNT_W-1:COUNT_W])) ||
    (tally_i[2*COUNT_W-1:COUNT_W] == $past(tally_i[2*COUNT_W-1:COUNT_W]) + 1'b1));

  // R4
  p_filt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tally_i[COUNT_W-1:0] == $past(tally_i[COUNT_W-1:0])) ||
    (tally_i[COUNT_W-1:0] == $past(tally_i[COUNT_W-1:0]) + 1'b1));

  // R5
  p_rise_settled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filtered_i) |-> hi_run_q >= NEED);

  // R6
  p_fall_settled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filtered_i) |-> lo_run_q >= NEED);

endmodule

bind press_tally pt_checker #(
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .COUNT_W       (COUNT_W)
) u_pt_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tally_i    (tally_o),
  .synced_i   (btn_sync),
  .filtered_i (path_level[0])
);

// File: tb/tb_press_tally.sv
module tb_press_tally;

  localparam int S = 6;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        button;
  logic [15:0] tally;

  int   tests = 0;
  int   fails = 0;
  int   exp_deb = 0;
  int   exp_raw = 0;
  logic last = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  press_tally #(.SETTLE_CYCLES(S)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .button_i (button),
    .tally_o  (tally)
  );

  task automatic check(input string tag);
    logic [15:0] exp;
    exp = {8'(exp_raw), 8'(exp_deb)};
    tests++;
    if (tally !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, tally, exp);
    end
  endtask

  // Drive a level for n clock samples, tracking sampled rising edges.
  task automatic hold(input logic lvl, input int n);
    if (lvl && !last) exp_raw++;
    last   = lvl;
    button = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int hi);
    hold(1'b1, hi);
    hold(1'b0, 2*S + 8);
  endtask

  initial begin
    rst_ni = 1'b1;
    button = 1'b0;
    #2 rst_ni = 1'b0;
    @(negedge clk);
    check("R1 during reset");
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 after release, button low");

    // R2: latency through the two synchronizer flops and the one-shot.
    button = 1'b1;
    last   = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 unchanged after three edges");
    @(negedge clk);
    exp_raw++;
    check("R2 raw count after fourth edge");
    repeat (S + 10) @(negedge clk);
    hold(1'b0, 2*S + 8);
    exp_deb++;
    check("R4 first clean press");

    // R5: boundary of the rise window.
    hold(1'b1, S);
    hold(1'b0, 2*S + 8);
    check("R5 high for SETTLE samples ignored");
    hold(1'b1, S + 1);
    hold(1'b0, 2*S + 8);
    exp_deb++;
    check("R5 high for SETTLE+1 samples counted");

    // R6: boundary of the fall window.
    hold(1'b1, S + 4);
    hold(1'b0, S);
    hold(1'b1, S + 4);
    hold(1'b0, 2*S + 8);
    exp_deb++;
    check("R6 short low gap inside press");
    hold(1'b1, S + 4);
    hold(1'b0, S + 1);
    hold(1'b1, S + 4);
    hold(1'b0, 2*S + 8);
    exp_deb += 2;
    check("R6 low gap of SETTLE+1 splits press");

    // R3/R4 sweep: bounce count and bounce width.
    for (int nb = 0; nb < 4; nb++) begin
      for (int w = 1; w <= S; w++) begin
        for (int k = 0; k < nb; k++) begin
          hold(1'b1, w);
          hold(1'b0, 1 + (k % 2));
        end
        hold(1'b1, S + 4);
        for (int k = 0; k < nb; k++) begin
          hold(1'b0, w);
          hold(1'b1, 1);
        end
        hold(1'b0, 2*S + 8);
        exp_deb++;
        check($sformatf("R3 R4 bounce sweep nb=%0d w=%0d", nb, w));
      end
    end

    // R4: held button counts once.
    hold(1'b1, 100);
    exp_deb++;
    check("R4 held button mid-hold");
    hold(1'b1, 100);
    check("R4 held button no further counts");
    hold(1'b0, 2*S + 8);
    check("R4 held button after release");

    // R3: unfiltered wrap under a long burst of one-cycle pulses.
    for (int i = 0; i < 300; i++) begin
      hold(1'b1, 1);
      hold(1'b0, 1);
    end
    hold(1'b0, 2*S + 8);
    check("R3 raw wrap, R8 byte packing");

    // R7: filtered wrap.
    while ((exp_deb % 256) != 255) begin
      exp_deb++;
      press(S + 2);
      exp_deb--;
      exp_deb++;
    end
    check("R7 filtered count at 255");
    press(S + 2);
    exp_deb++;
    check("R7 filtered count wraps to 0");

    // R9: asynchronous clear in mid-operation.
    press(S + 2);
    exp_deb++;
    check("R9 nonzero before reset");
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    exp_deb = 0;
    exp_raw = 0;
    check("R9 cleared without clock edge");
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    last   = 1'b0;
    repeat (8) @(negedge clk);
    check("R1 zero after mid-run reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule